// File: doc/BRIEF.md
# Paged Address Translator with Associative Cache

This block maps the logical addresses of one process onto physical memory through a page table kept in main memory. A small, fully associative cache of page-to-frame pairs sits in front of that table. The logical address splits into a page number, which is the upper bits, and an offset, which is the lower bits. The page number is compared against every cached pair in a single cycle. On a hit, the translator goes straight to the data access. On a miss, it first reads the page table entry at the table base plus the page number. It then performs the data access and loads the new pair into the cache in the same cycle that the data access is issued.

The block has one memory port. The page-table reads and the final data reads and writes all share it. The memory answers a request with read data one cycle later. Two configuration inputs, the table base address and the table length in pages, are held steady by the surrounding logic.

The translator reports two faults. A page number outside the table raises a range fault, and a write to a read-only page raises a protection fault. A faulting request never writes memory.

A page table entry is one memory word with this layout:
- bits [FRAME_W-1:0] hold the frame number;
- bit 15 is the read-only flag;
- bit 14 is the dirty flag.

Top module: `xlat_top`

## Requirements
- R1: The offset is logical address bits [3:0] and the page number is bits [11:4]. On a completed access, `xl_paddr` equals the frame number followed by the unchanged offset, and the data access uses that address: reads return the word stored there and writes store `xl_wdata` there.
- R2: On a cache miss, exactly two memory requests are made. The first is a read of the page table entry at `cfg_ptbase` plus the page number. In that entry, bits [7:0] are the frame, bit 15 is read-only and bit 14 is dirty. The second request is the data access.
- R3: On a cache hit, exactly one memory request is made, the data access, and at most one cached entry matches any page number.
- R4: The new cache entry is written in the same cycle as the data access. `xl_done` rises 3 cycles after the request cycle on a hit and 4 cycles after it on a miss.
- R5: A page number greater than or equal to `cfg_ptlen` sets `xl_fault_range` with `xl_done` 2 cycles after the request, and no memory request is made.
- R6: A write to a page whose read-only bit is set sets `xl_fault_ro` and never asserts `mem_we`. This takes 2 cycles on a hit and 3 on a miss, with one memory request (the table read) on a miss. Reads of a read-only page complete normally.
- R7: On a completed access, `xl_dirty` is 1 if the entry's dirty bit was set when it was loaded, or if any write to that cached page has completed since it was loaded, including the present one.
- R8: A miss loads the lowest-numbered empty entry if there is one. Once all 8 entries are full, the victim is chosen round-robin, starting at entry 0 and advancing by one after each replacement.
- R9: A `tlb_flush` pulse while idle empties every entry and returns the round-robin pointer to entry 0, so the next access to any page misses.
- R10: After reset, the cache is empty, `xl_done` and both fault flags are 0, and no memory request is made while idle.
- R11: `xl_done` is a one-cycle pulse, and the result outputs hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ptbase | input | PA_W | Physical address of page table entry 0 |
| cfg_ptlen | input | VPN_W+1 | Number of valid pages in the table |
| tlb_flush | input | 1 | Empties the associative cache |
| xl_req | input | 1 | One-cycle request strobe, accepted when idle |
| xl_we | input | 1 | 1 = write access, 0 = read access |
| xl_laddr | input | LA_W | Logical address |
| xl_wdata | input | DW | Write data |
| xl_done | output | 1 | Completion pulse |
| xl_paddr | output | PA_W | Translated physical address |
| xl_rdata | output | DW | Read data of the completed access |
| xl_dirty | output | 1 | Dirty state of the accessed page |
| xl_fault_range | output | 1 | Page number beyond table length |
| xl_fault_ro | output | 1 | Write to a read-only page |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | PA_W | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after a request |

## Verification
The bench first covers the boundary pages. Page length minus one must translate, and page length itself must fault without any memory traffic; an off-by-one compare would either fetch a nonexistent entry or reject the last page. It then writes a read-only page through both the miss path and the hit path and checks that memory is untouched; a design that tests protection only on hits would corrupt the word on the first write. Finally, it fills the cache, forces evictions and counts memory requests to confirm which pages still hit. A design that overwrote entry 0 on every fill, or that started round-robin replacement before the cache was full, would show misses where hits are expected.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
    typedef enum logic [1:0] {
        XS_IDLE,
        XS_CHECK,
        XS_WALK,
        XS_DATA
    } xl_state_e;
endpackage

// File: rtl/xlat_tlb.sv
`timescale 1ns/1ps
module xlat_tlb #(
    parameter int N       = 8,
    parameter int VPN_W   = 8,
    parameter int FRAME_W = 8,
    localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic [N-1:0]       hit_vec,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [FRAME_W-1:0] hit_frame,
    output logic               hit_ro,
    output logic               hit_dirty,
    output logic [N-1:0]       valid_vec,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic               fill_ro,
    input  logic               fill_dirty,
    input  logic               mark_en,
    input  logic [IDX_W-1:0]   mark_idx
);
    typedef struct packed {
        logic               v;
        logic [VPN_W-1:0]   vpn;
        logic [FRAME_W-1:0] frame;
        logic               ro;
        logic               dirty;
    } ent_t;

    ent_t ent_q [N];
    ent_t ent_d [N];

    // parallel compare of every entry against the page number
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g]   = ent_q[g].v && (ent_q[g].vpn == lk_vpn);
        assign valid_vec[g] = ent_q[g].v;
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_idx   = '0;
        hit_frame = '0;
        hit_ro    = 1'b0;
        hit_dirty = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                hit_idx   = IDX_W'(i);
                hit_frame = ent_q[i].frame;
                hit_ro    = ent_q[i].ro;
                hit_dirty = ent_q[i].dirty;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ent_d[i] = ent_q[i];
            if (flush) ent_d[i].v = 1'b0;
        end
        if (mark_en) ent_d[mark_idx].dirty = 1'b1;
        if (fill_en) begin
            ent_d[fill_idx].v     = 1'b1;
            ent_d[fill_idx].vpn   = fill_vpn;
            ent_d[fill_idx].frame = fill_frame;
            ent_d[fill_idx].ro    = fill_ro;
            ent_d[fill_idx].dirty = fill_dirty;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) ent_q[i] <= ent_d[i];
        end
    end
endmodule

// File: rtl/xlat_victim.sv
`timescale 1ns/1ps
module xlat_victim #(
    parameter int N      = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid_vec,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] victim,
    output logic             all_full
);
    logic found;

    always_comb begin
        all_full = &valid_vec;
        victim   = rr_ptr;
        found    = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found && !valid_vec[i]) begin
                victim = IDX_W'(i);
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlat_top.sv
`timescale 1ns/1ps
module xlat_top #(
    parameter int LA_W   = 12,
    parameter int OFF_W  = 4,
    parameter int PA_W   = 12,
    parameter int DW     = 16,
    parameter int TLB_N  = 8,
    localparam int VPN_W   = LA_W - OFF_W,
    localparam int FRAME_W = PA_W - OFF_W,
    localparam int IDX_W   = (TLB_N > 1) ? $clog2(TLB_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PA_W-1:0]  cfg_ptbase,
    input  logic [VPN_W:0]   cfg_ptlen,
    input  logic             tlb_flush,
    input  logic             xl_req,
    input  logic             xl_we,
    input  logic [LA_W-1:0]  xl_laddr,
    input  logic [DW-1:0]    xl_wdata,
    output logic             xl_done,
    output logic [PA_W-1:0]  xl_paddr,
    output logic [DW-1:0]    xl_rdata,
    output logic             xl_dirty,
    output logic             xl_fault_range,
    output logic             xl_fault_ro,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata
);
    import xlat_pkg::*;

    // page table entry layout: frame low, read-only at top bit, dirty below it
    localparam int PTE_RO  = DW - 1;
    localparam int PTE_DTY = DW - 2;

    typedef struct packed {
        xl_state_e          st;
        logic [VPN_W-1:0]   vpn;
        logic [OFF_W-1:0]   off;
        logic               we;
        logic [DW-1:0]      wdata;
        logic               done;
        logic [PA_W-1:0]    paddr;
        logic [DW-1:0]      rdata;
        logic               dirty;
        logic               f_range;
        logic               f_ro;
        logic [IDX_W-1:0]   rr;
    } st_t;

    st_t s_q, s_d;

    logic [TLB_N-1:0]   hit_vec, valid_vec;
    logic               hit, hit_ro, hit_dirty, all_full;
    logic [IDX_W-1:0]   hit_idx, vic_idx;
    logic [FRAME_W-1:0] hit_frame;
    logic               fill_en, fill_dirty, mark_en;
    logic [FRAME_W-1:0] pte_frame;
    logic               pte_ro, pte_dirty;
    logic               out_of_range;

    assign pte_frame    = mem_rdata[FRAME_W-1:0];
    assign pte_ro       = mem_rdata[PTE_RO];
    assign pte_dirty    = mem_rdata[PTE_DTY];
    assign out_of_range = ({1'b0, s_q.vpn} >= cfg_ptlen);

    xlat_tlb #(.N(TLB_N), .VPN_W(VPN_W), .FRAME_W(FRAME_W)) u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (tlb_flush),
        .lk_vpn     (s_q.vpn),
        .hit_vec    (hit_vec),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .hit_frame  (hit_frame),
        .hit_ro     (hit_ro),
        .hit_dirty  (hit_dirty),
        .valid_vec  (valid_vec),
        .fill_en    (fill_en),
        .fill_idx   (vic_idx),
        .fill_vpn   (s_q.vpn),
        .fill_frame (pte_frame),
        .fill_ro    (pte_ro),
        .fill_dirty (fill_dirty),
        .mark_en    (mark_en),
        .mark_idx   (hit_idx)
    );

    xlat_victim #(.N(TLB_N)) u_vic (
        .valid_vec (valid_vec),
        .rr_ptr    (s_q.rr),
        .victim    (vic_idx),
        .all_full  (all_full)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = s_q.wdata;
        fill_en    = 1'b0;
        fill_dirty = pte_dirty;
        mark_en    = 1'b0;

        unique case (s_q.st)
            XS_IDLE: begin
                if (xl_req) begin
                    s_d.st    = XS_CHECK;
                    s_d.vpn   = xl_laddr[LA_W-1:OFF_W];
                    s_d.off   = xl_laddr[OFF_W-1:0];
                    s_d.we    = xl_we;
                    s_d.wdata = xl_wdata;
                end
            end
            XS_CHECK: begin
                if (out_of_range) begin
                    s_d.done    = 1'b1;
                    s_d.f_range = 1'b1;
                    s_d.f_ro    = 1'b0;
                    s_d.st      = XS_IDLE;
                end else if (hit) begin
                    if (s_q.we && hit_ro) begin
                        s_d.done    = 1'b1;
                        s_d.f_range = 1'b0;
                        s_d.f_ro    = 1'b1;
                        s_d.st      = XS_IDLE;
                    end else begin
                        mem_req   = 1'b1;
                        mem_we    = s_q.we;
                        mem_addr  = {hit_frame, s_q.off};
                        mark_en   = s_q.we;
                        s_d.paddr = {hit_frame, s_q.off};
                        s_d.dirty = hit_dirty | s_q.we;
                        s_d.st    = XS_DATA;
                    end
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = cfg_ptbase + PA_W'(s_q.vpn);
                    s_d.st   = XS_WALK;
                end
            end
            XS_WALK: begin
                fill_en = 1'b1;
                if (all_full) begin
                    s_d.rr = (s_q.rr == IDX_W'(TLB_N - 1)) ? '0 : s_q.rr + 1'b1;
                end
                if (s_q.we && pte_ro) begin
                    s_d.done    = 1'b1;
                    s_d.f_range = 1'b0;
                    s_d.f_ro    = 1'b1;
                    s_d.st      = XS_IDLE;
                end else begin
                    fill_dirty = pte_dirty | s_q.we;
                    mem_req    = 1'b1;
                    mem_we     = s_q.we;
                    mem_addr   = {pte_frame, s_q.off};
                    s_d.paddr  = {pte_frame, s_q.off};
                    s_d.dirty  = pte_dirty | s_q.we;
                    s_d.st     = XS_DATA;
                end
            end
            XS_DATA: begin
                s_d.done    = 1'b1;
                s_d.rdata   = mem_rdata;
                s_d.f_range = 1'b0;
                s_d.f_ro    = 1'b0;
                s_d.st      = XS_IDLE;
            end
            default: s_d.st = XS_IDLE;
        endcase

        if (tlb_flush) s_d.rr = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= XS_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign xl_done        = s_q.done;
    assign xl_paddr       = s_q.paddr;
    assign xl_rdata       = s_q.rdata;
    assign xl_dirty       = s_q.dirty;
    assign xl_fault_range = s_q.f_range;
    assign xl_fault_ro    = s_q.f_ro;
endmodule

// File: rtl/xlat_chk.sv
`timescale 1ns/1ps
module xlat_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         idle,
    input logic         xl_done,
    input logic         xl_fault_range,
    input logic         xl_fault_ro,
    input logic         mem_req,
    input logic         mem_we,
    input logic [N-1:0] hit_vec
);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_done |=> !xl_done);

    // R5
    range_noacc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_done && xl_fault_range) |-> !$past(mem_req));

    // R6
    ro_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_done && xl_fault_ro) |-> !$past(mem_we));

    // R3
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mem_req);
endmodule

bind xlat_top xlat_chk #(.N(TLB_N)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .idle           (s_q.st == xlat_pkg::XS_IDLE),
    .xl_done        (xl_done),
    .xl_fault_range (xl_fault_range),
    .xl_fault_ro    (xl_fault_ro),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .hit_vec        (hit_vec)
);

// File: tb/sim_xlat_top.sv
`timescale 1ns/1ps
module sim_xlat_top;
    localparam int NV = 12;
    localparam logic [2:0] K_HIT = 3'd0, K_MISS = 3'd1, K_RANGE = 3'd2,
                           K_ROH = 3'd3, K_ROM = 3'd4;
    // {we, page[7:0], offset[3:0], wdata[15:0], kind[2:0]}
    localparam logic [31:0] VEC [NV] = '{
        {1'b0, 8'd1,  4'd2,  16'h0000, K_MISS },
        {1'b0, 8'd1,  4'd7,  16'h0000, K_HIT  },
        {1'b0, 8'd70, 4'd0,  16'h0000, K_RANGE},
        {1'b1, 8'd5,  4'd1,  16'h5555, K_ROM  },
        {1'b1, 8'd5,  4'd1,  16'h6666, K_ROH  },
        {1'b0, 8'd5,  4'd9,  16'h0000, K_HIT  },
        {1'b1, 8'd2,  4'd3,  16'h1234, K_MISS },
        {1'b0, 8'd2,  4'd3,  16'h0000, K_HIT  },
        {1'b0, 8'd4,  4'd0,  16'h0000, K_MISS },
        {1'b0, 8'd63, 4'd15, 16'h0000, K_MISS },
        {1'b0, 8'd64, 4'd0,  16'h0000, K_RANGE},
        {1'b1, 8'd1,  4'd4,  16'hBEEF, K_HIT  }
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cfg_ptbase = 12'h800;
    logic [8:0]  cfg_ptlen = 9'd64;
    logic        tlb_flush = 1'b0;
    logic        xl_req = 1'b0, xl_we = 1'b0;
    logic [11:0] xl_laddr = '0;
    logic [15:0] xl_wdata = '0;
    logic        xl_done, xl_dirty, xl_fault_range, xl_fault_ro;
    logic [11:0] xl_paddr, mem_addr;
    logic [15:0] xl_rdata, mem_wdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_rdata = '0;

    logic [15:0] mem [4096];
    logic        dshadow [256];

    int n_tests = 0, n_fail = 0;
    bit finished = 0;
    int r_acc, r_wr, r_lat;
    logic [11:0] r_paddr;
    logic [15:0] r_rdata;
    logic r_dirty, r_fr, r_fro;

    always #2.5 clk = ~clk;

    xlat_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_ptbase(cfg_ptbase), .cfg_ptlen(cfg_ptlen),
        .tlb_flush(tlb_flush), .xl_req(xl_req), .xl_we(xl_we), .xl_laddr(xl_laddr),
        .xl_wdata(xl_wdata), .xl_done(xl_done), .xl_paddr(xl_paddr),
        .xl_rdata(xl_rdata), .xl_dirty(xl_dirty), .xl_fault_range(xl_fault_range),
        .xl_fault_ro(xl_fault_ro), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // one-cycle memory model
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            mem_rdata <= mem[mem_addr];
        end
    end

    function automatic logic [7:0] frm(input logic [7:0] v);
        logic [15:0] t;
        t = 16'(v) * 16'd5 + 16'd3;
        return {1'b0, t[6:0]};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic xact(input logic we, input logic [7:0] pg, input logic [3:0] off,
                        input logic [15:0] wd);
        @(negedge clk);
        xl_req = 1'b1; xl_we = we; xl_laddr = {pg, off}; xl_wdata = wd;
        r_acc = 0; r_wr = 0; r_lat = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            xl_req = 1'b0;
            r_lat++;
            if (mem_req) r_acc++;
            if (mem_req && mem_we) r_wr++;
            if (xl_done) break;
        end
        r_paddr = xl_paddr; r_rdata = xl_rdata; r_dirty = xl_dirty;
        r_fr = xl_fault_range; r_fro = xl_fault_ro;
    endtask

    task automatic rd_expect(input logic [7:0] pg, input int acc, input string rq);
        xact(1'b0, pg, 4'd0, 16'h0);
        chk(r_acc == acc, rq, $sformatf("accesses page %0d", pg), r_acc, acc);
    endtask

    initial begin
        for (int a = 0; a < 2048; a++) mem[a] = 16'(a * 7) ^ 16'h3C00;
        for (int v = 0; v < 256; v++) begin
            mem[12'h800 + v] = {(v % 8 == 5), (v == 4), 6'b0, frm(8'(v))};
            dshadow[v] = (v == 4);
        end
        for (int a = 2304; a < 4096; a++) mem[a] = '0;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk(xl_done == 0 && xl_fault_range == 0 && xl_fault_ro == 0, "R10",
            "outputs in reset", {xl_done, xl_fault_range, xl_fault_ro}, 0);
        rst_n = 1'b1;
        begin
            int seen = 0;
            repeat (5) begin @(negedge clk); if (mem_req) seen++; end
            chk(seen == 0, "R10", "idle requests", seen, 0);
        end

        for (int i = 0; i < NV; i++) begin
            logic we; logic [7:0] pg; logic [3:0] off; logic [15:0] wd; logic [2:0] k;
            logic [11:0] epa; logic [15:0] erd; bit ok_kind;
            {we, pg, off, wd, k} = VEC[i];
            epa = {frm(pg), off};
            erd = mem[epa];
            ok_kind = (k == K_HIT || k == K_MISS);
            if (we && ok_kind) dshadow[pg] = 1'b1;
            xact(we, pg, off, wd);
            case (k)
                K_HIT: begin
                    chk(r_acc == 1, "R3", "hit accesses", r_acc, 1);
                    chk(r_lat == 3, "R4", "hit latency", r_lat, 3);
                end
                K_MISS: begin
                    chk(r_acc == 2, "R2", "miss accesses", r_acc, 2);
                    chk(r_lat == 4, "R4", "miss latency", r_lat, 4);
                end
                K_RANGE: begin
                    chk(r_fr && !r_fro, "R5", "range flag", {r_fr, r_fro}, 2);
                    chk(r_acc == 0 && r_lat == 2, "R5", "range acc/lat",
                        r_acc * 16 + r_lat, 2);
                end
                default: begin
                    int ea, el;
                    ea = (k == K_ROM) ? 1 : 0;
                    el = (k == K_ROM) ? 3 : 2;
                    chk(r_fro && !r_fr, "R6", "ro flag", {r_fr, r_fro}, 1);
                    chk(r_acc == ea && r_wr == 0 && r_lat == el, "R6", "ro acc/wr/lat",
                        r_acc * 256 + r_wr * 16 + r_lat, ea * 256 + el);
                    chk(mem[epa] == erd, "R6", "ro word unchanged", mem[epa], erd);
                end
            endcase
            if (ok_kind) begin
                chk(r_paddr == epa, "R1", "paddr", r_paddr, epa);
                chk(!r_fr && !r_fro, "R1", "no fault", {r_fr, r_fro}, 0);
                if (we) begin
                    chk(mem[epa] == wd && r_wr == 1, "R1", "written word", mem[epa], wd);
                end else begin
                    chk(r_rdata == erd, "R1", "read data", r_rdata, erd);
                end
                chk(r_dirty == dshadow[pg], "R7", "dirty", r_dirty, dshadow[pg]);
            end
        end

        // R11: outputs hold after completion
        repeat (4) @(negedge clk);
        chk(xl_done == 0 && xl_paddr == r_paddr, "R11", "held paddr", xl_paddr, r_paddr);

        // R9: flush forces a miss on a previously cached page
        @(negedge clk); tlb_flush = 1'b1;
        @(negedge clk); tlb_flush = 1'b0;
        rd_expect(8'd1, 2, "R9");

        // R8: empty entries first, then round-robin from entry 0
        for (int p = 10; p < 17; p++) rd_expect(8'(p), 2, "R8");
        rd_expect(8'd1, 1, "R8");
        rd_expect(8'd10, 1, "R8");
        rd_expect(8'd20, 2, "R8");
        rd_expect(8'd16, 1, "R8");
        rd_expect(8'd1, 2, "R8");
        rd_expect(8'd10, 2, "R8");
        rd_expect(8'd12, 1, "R8");
        rd_expect(8'd11, 2, "R8");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule